// File: doc/BRIEF.md
# Edge Interrupt and Event Controller

This block turns a set of asynchronous input lines into interrupt and event signals. Each line first passes through a two-flop synchroniser and an edge detector. Separate enable bits choose whether a line reacts to its rising transition, its falling transition, both, or neither. A qualified rising transition and a qualified falling transition set flags in two separate pending registers, so software can tell which transition occurred. Each pending bit stays set until software writes a one to it.

Two independent masks sit on every line. The interrupt mask gates that line's pending flags into one combined request output. The event mask turns each qualified transition into a single-cycle pulse on that line's event output, whatever state the pending flags are in. Software can also raise a line's rising-pending flag directly. The lower sixteen lines each draw their input from one of several GPIO ports through a selector field. The remaining lines have dedicated inputs.

Each line carries a privilege attribute and a security attribute. These attributes decide which accesses may change that line's bits. A sticky lock bit freezes both attribute registers until reset. Configuration goes through a plain synchronous register port. A write is taken on the clock edge where `reg_wr` is high. Read data follows `reg_addr` combinationally. The port never stalls, so it has no back-pressure.

Top module: `edge_irq_ctrl`

## Requirements
- R1: An input change is seen through a two-flop synchroniser. A qualified transition driven before clock edge k shows in the pending register after edge k+2, and does not show after edge k+1.
- R2: Bits in RISE_EN (address 0) and FALL_EN (address 1) are independent per line.
  - A rising transition sets the line's bit in RISE_PEND (address 2) only when its RISE_EN bit is 1.
  - A falling transition sets the line's bit in FALL_PEND (address 3) only when its FALL_EN bit is 1.
  - With both bits set the line reacts to either transition. With both clear it reacts to neither.
- R3: Writing a word to RISE_PEND or FALL_PEND clears exactly the bits written as 1 and leaves every other pending bit unchanged. A transition arriving in the same cycle as the clear wins.
- R4: `irq_o` is high exactly when some line has a rising or falling pending bit set while its IRQ_MASK bit (address 4) is 1.
- R5: `evt_o[i]` is a one-cycle pulse, aligned with the pending update, for each qualified transition on line i while its EVT_MASK bit (address 5) is 1. It fires whether or not the pending bit is already set.
- R6: Writing 1 to a bit of SWTRIG (address 6) sets that line's RISE_PEND bit on the write edge. It does not touch FALL_PEND, and SWTRIG reads as 0.
- R7: The selector for line g (g < 16) is a field at register address 12 + g/4, bits starting at 8*(g mod 4).
  - Only the low $clog2(NUM_PORTS+1) bits of each field are stored, and the other bits read as 0.
  - A value v < NUM_PORTS routes `gpio_in[v*16+g]` to line g.
  - Any larger value routes a constant 0.
- R8: Lines 16 to NUM_LINES-1 take their input from `direct_in[line-16]`.
- R9: A write to a per-line register changes a line's bit (or selector field, or raises a trigger or clear) only under two conditions:
  - If the line's PRIV bit is 1, the write must have `reg_priv` high.
  - If the line's SEC bit is 1, the write must have `reg_sec` high.
- R10: PRIV (address 7) and SEC (address 8) reset to 0.
  - PRIV accepts writes only with `reg_priv` high, and bits of secure lines also need `reg_sec`.
  - SEC accepts writes only with `reg_sec` high, and bits of privileged lines also need `reg_priv`.
- R11: LOCK (address 9, bit 0) is set by a privileged write of 1 and reads back in bit 0. Once set, it stays set until reset, and all writes to PRIV and SEC are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_in | input | NUM_PORTS*16 | Asynchronous GPIO pins, port p pin g at bit p*16+g |
| direct_in | input | NUM_LINES-16 | Asynchronous inputs of the upper lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_priv | input | 1 | Access is privileged |
| reg_sec | input | 1 | Access is secure |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | NUM_LINES | Per-line event pulses |

## Verification
The assertions check four properties on every cycle:
- Pending bits never drop without a clear write to their register.
- The lock never falls once set, and while it is set the attribute registers hold steady.
- Unprivileged writes never alter the interrupt mask of privileged lines.
- An event pulse only appears on a line whose event mask was set.

Other behaviours can only be shown by the bench's scenarios. These are:
- the exact three-edge latency;
- the sweep over every line and every enable combination;
- selector routing, including out-of-range values;
- the combined request level;
- the full set of attribute rules.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 4;
  localparam int GPIO_LINES    = 16;
  localparam int LINES_PER_SEL = 4;
  localparam int SEL_FIELD_W   = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_RISE_EN   = 4'd0,
    A_FALL_EN   = 4'd1,
    A_RISE_PEND = 4'd2,
    A_FALL_PEND = 4'd3,
    A_IRQ_MASK  = 4'd4,
    A_EVT_MASK  = 4'd5,
    A_SWTRIG    = 4'd6,
    A_PRIV      = 4'd7,
    A_SEC       = 4'd8,
    A_LOCK      = 4'd9,
    A_PSEL0     = 4'd12,
    A_PSEL1     = 4'd13,
    A_PSEL2     = 4'd14,
    A_PSEL3     = 4'd15
  } reg_addr_e;

  function automatic logic [ADDR_W-1:0] psel_addr(input int line);
    return ADDR_W'(int'(A_PSEL0) + line / LINES_PER_SEL);
  endfunction
endpackage

// File: rtl/eic_line_sync.sv
module eic_line_sync #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/eic_port_mux.sv
module eic_port_mux
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int SEL_W     = 2
) (
  input  logic [NUM_PORTS*GPIO_LINES-1:0] gpio_in,
  input  logic [GPIO_LINES*SEL_W-1:0]     sel_flat,
  output logic [GPIO_LINES-1:0]           line_out
);
  for (genvar g = 0; g < GPIO_LINES; g++) begin : g_line
    logic [SEL_W-1:0] sel;
    assign sel = sel_flat[g*SEL_W +: SEL_W];
    always_comb begin
      line_out[g] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(sel) == p) line_out[g] = gpio_in[p*GPIO_LINES + g];
      end
    end
  end
endmodule

// File: rtl/eic_pend.sv
module eic_pend #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_det,
  input  logic [N-1:0] fall_det,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] irq_mask,
  input  logic [N-1:0] evt_mask,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] clr_rise,
  input  logic [N-1:0] clr_fall,
  output logic [N-1:0] rise_pend,
  output logic [N-1:0] fall_pend,
  output logic [N-1:0] evt_o,
  output logic         irq_o
);
  logic [N-1:0] hit_r, hit_f;

  assign hit_r = rise_det & rise_en;
  assign hit_f = fall_det & fall_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_pend <= '0;
      fall_pend <= '0;
      evt_o     <= '0;
    end else begin
      rise_pend <= (rise_pend & ~clr_rise) | hit_r | sw_set;
      fall_pend <= (fall_pend & ~clr_fall) | hit_f;
      evt_o     <= (hit_r | hit_f) & evt_mask;
    end
  end

  assign irq_o = |((rise_pend | fall_pend) & irq_mask);
endmodule

// File: rtl/eic_cfg.sv
module eic_cfg
  import edge_irq_pkg::*;
#(
  parameter int N     = 20,
  parameter int SEL_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic                        reg_priv,
  input  logic                        reg_sec,
  input  logic [N-1:0]                rise_pend,
  input  logic [N-1:0]                fall_pend,
  output logic [N-1:0]                rise_en,
  output logic [N-1:0]                fall_en,
  output logic [N-1:0]                irq_mask,
  output logic [N-1:0]                evt_mask,
  output logic [N-1:0]                priv_attr,
  output logic [N-1:0]                sec_attr,
  output logic                        lock_q,
  output logic [N-1:0]                sw_set,
  output logic [N-1:0]                clr_rise,
  output logic [N-1:0]                clr_fall,
  output logic [GPIO_LINES*SEL_W-1:0] sel_flat,
  output logic [DATA_W-1:0]           reg_rdata
);
  logic [N-1:0]     wd, line_ok, sec_ok, priv_ok;
  logic [SEL_W-1:0] sel_q [GPIO_LINES];
  logic             unused_wdata;

  assign wd           = reg_wdata[N-1:0];
  assign unused_wdata = ^reg_wdata;
  assign sec_ok       = ~sec_attr  | {N{reg_sec}};
  assign priv_ok      = ~priv_attr | {N{reg_priv}};
  assign line_ok      = sec_ok & priv_ok;

  function automatic logic [N-1:0] merge(input logic [N-1:0] old_v,
                                         input logic [N-1:0] new_v,
                                         input logic [N-1:0] ok);
    return (old_v & ~ok) | (new_v & ok);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en   <= '0;
      fall_en   <= '0;
      irq_mask  <= '0;
      evt_mask  <= '0;
      priv_attr <= '0;
      sec_attr  <= '0;
      lock_q    <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_RISE_EN:  rise_en  <= merge(rise_en, wd, line_ok);
        A_FALL_EN:  fall_en  <= merge(fall_en, wd, line_ok);
        A_IRQ_MASK: irq_mask <= merge(irq_mask, wd, line_ok);
        A_EVT_MASK: evt_mask <= merge(evt_mask, wd, line_ok);
        A_PRIV: if (reg_priv && !lock_q) priv_attr <= merge(priv_attr, wd, sec_ok);
        A_SEC:  if (reg_sec && !lock_q)  sec_attr  <= merge(sec_attr, wd, priv_ok);
        A_LOCK: if (reg_priv && reg_wdata[0]) lock_q <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < GPIO_LINES; g++) sel_q[g] <= '0;
    end else begin
      for (int g = 0; g < GPIO_LINES; g++) begin
        if (reg_wr && reg_addr == psel_addr(g) && line_ok[g])
          sel_q[g] <= reg_wdata[SEL_FIELD_W*(g%LINES_PER_SEL) +: SEL_W];
      end
    end
  end

  for (genvar g = 0; g < GPIO_LINES; g++) begin : g_flat
    assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];
  end

  always_comb begin
    sw_set   = '0;
    clr_rise = '0;
    clr_fall = '0;
    if (reg_wr) begin
      if (reg_addr == A_SWTRIG)    sw_set   = wd & line_ok;
      if (reg_addr == A_RISE_PEND) clr_rise = wd & line_ok;
      if (reg_addr == A_FALL_PEND) clr_fall = wd & line_ok;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RISE_EN:   reg_rdata[N-1:0] = rise_en;
      A_FALL_EN:   reg_rdata[N-1:0] = fall_en;
      A_RISE_PEND: reg_rdata[N-1:0] = rise_pend;
      A_FALL_PEND: reg_rdata[N-1:0] = fall_pend;
      A_IRQ_MASK:  reg_rdata[N-1:0] = irq_mask;
      A_EVT_MASK:  reg_rdata[N-1:0] = evt_mask;
      A_PRIV:      reg_rdata[N-1:0] = priv_attr;
      A_SEC:       reg_rdata[N-1:0] = sec_attr;
      A_LOCK:      reg_rdata[0]     = lock_q;
      A_PSEL0, A_PSEL1, A_PSEL2, A_PSEL3: begin
        for (int g = 0; g < GPIO_LINES; g++) begin
          if (psel_addr(g) == reg_addr)
            reg_rdata[SEL_FIELD_W*(g%LINES_PER_SEL) +: SEL_W] = sel_q[g];
        end
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = 20,
  parameter int NUM_PORTS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PORTS*GPIO_LINES-1:0] gpio_in,
  input  logic [NUM_LINES-GPIO_LINES-1:0] direct_in,
  input  logic                            reg_wr,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  input  logic                            reg_priv,
  input  logic                            reg_sec,
  output logic [DATA_W-1:0]               reg_rdata,
  output logic                            irq_o,
  output logic [NUM_LINES-1:0]            evt_o
);
  localparam int SEL_W = $clog2(NUM_PORTS + 1);

  logic [NUM_LINES-1:0]        raw_lines, rise_det, fall_det;
  logic [NUM_LINES-1:0]        rise_en, fall_en, irq_mask, evt_mask;
  logic [NUM_LINES-1:0]        priv_attr, sec_attr;
  logic [NUM_LINES-1:0]        sw_set, clr_rise, clr_fall;
  logic [NUM_LINES-1:0]        rise_pend, fall_pend;
  logic [GPIO_LINES-1:0]       mux_lines;
  logic [GPIO_LINES*SEL_W-1:0] sel_flat;
  logic                        lock_q;

  eic_port_mux #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_mux (
    .gpio_in  (gpio_in),
    .sel_flat (sel_flat),
    .line_out (mux_lines)
  );

  assign raw_lines = {direct_in, mux_lines};

  eic_line_sync #(.N(NUM_LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw_lines),
    .rise (rise_det),
    .fall (fall_det)
  );

  eic_cfg #(.N(NUM_LINES), .SEL_W(SEL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_priv  (reg_priv),
    .reg_sec   (reg_sec),
    .rise_pend (rise_pend),
    .fall_pend (fall_pend),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .irq_mask  (irq_mask),
    .evt_mask  (evt_mask),
    .priv_attr (priv_attr),
    .sec_attr  (sec_attr),
    .lock_q    (lock_q),
    .sw_set    (sw_set),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall),
    .sel_flat  (sel_flat),
    .reg_rdata (reg_rdata)
  );

  eic_pend #(.N(NUM_LINES)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_det  (rise_det),
    .fall_det  (fall_det),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .irq_mask  (irq_mask),
    .evt_mask  (evt_mask),
    .sw_set    (sw_set),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall),
    .rise_pend (rise_pend),
    .fall_pend (fall_pend),
    .evt_o     (evt_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk
  import edge_irq_pkg::*;
#(
  parameter int N = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_priv,
  input logic [N-1:0]      rise_pend,
  input logic [N-1:0]      fall_pend,
  input logic [N-1:0]      irq_mask,
  input logic [N-1:0]      evt_mask,
  input logic [N-1:0]      priv_attr,
  input logic [N-1:0]      sec_attr,
  input logic              lock_q,
  input logic [N-1:0]      evt_o
);
  // R3
  rise_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_RISE_PEND) |=> ((rise_pend & $past(rise_pend)) == $past(rise_pend)));

  // R3
  fall_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_FALL_PEND) |=> ((fall_pend & $past(fall_pend)) == $past(fall_pend)));

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R11
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(priv_attr) && $stable(sec_attr)));

  // R9
  unpriv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_priv) |=> (((irq_mask ^ $past(irq_mask)) & $past(priv_attr)) == '0));

  // R5
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & ~$past(evt_mask)) == '0);
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.N(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_priv  (reg_priv),
  .rise_pend (rise_pend),
  .fall_pend (fall_pend),
  .irq_mask  (irq_mask),
  .evt_mask  (evt_mask),
  .priv_attr (priv_attr),
  .sec_attr  (sec_attr),
  .lock_q    (lock_q),
  .evt_o     (evt_o)
);

// File: tb/edge_irq_ctrl_bench.sv
`timescale 1ns/1ps
module edge_irq_ctrl_bench;
  localparam int NL = 20;
  localparam int NP = 3;
  localparam int SW = $clog2(NP + 1);
  localparam logic [3:0] RISE_EN = 4'd0, FALL_EN = 4'd1, RPEND = 4'd2, FPEND = 4'd3,
                         IRQM = 4'd4, EVTM = 4'd5, SWTRIG = 4'd6, PRIV = 4'd7,
                         SEC = 4'd8, LOCK = 4'd9, PSEL1 = 4'd13;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP*16-1:0] gpio_in = '0;
  logic [NL-17:0]   direct_in = '0;
  logic             reg_wr = 1'b0;
  logic [3:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic             reg_priv = 1'b1;
  logic             reg_sec = 1'b1;
  logic [31:0]      reg_rdata;
  logic             irq_o;
  logic [NL-1:0]    evt_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_irq_ctrl #(.NUM_LINES(NL), .NUM_PORTS(NP)) u_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .direct_in(direct_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_priv(reg_priv), .reg_sec(reg_sec), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d,
                    input logic p = 1'b1, input logic s = 1'b1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_priv = p; reg_sec = s;
    @(negedge clk);
    reg_wr = 1'b0; reg_priv = 1'b1; reg_sec = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_line(input int l, input logic v);
    if (l < 16) gpio_in[l] = v;
    else direct_in[l-16] = v;
  endtask

  task automatic clear_pend();
    wr(RPEND, 32'hFFFF_FFFF);
    wr(FPEND, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] allm;
    allm = (32'd1 << NL) - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R10, R11, R4)
    check("R4 reset irq", {31'b0, irq_o}, 0);
    check("R5 reset evt", 32'(evt_o), 0);
    rd(PRIV, v); check("R10 reset priv", v, 0);
    rd(SEC, v);  check("R10 reset sec", v, 0);
    rd(LOCK, v); check("R11 reset lock", v, 0);
    rd(RISE_EN, v); check("R2 reset rise_en", v, 0);

    // R1: latency through the synchroniser
    wr(RISE_EN, 32'h1);
    gpio_in[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(RPEND, v); check("R1 not yet after two edges", v, 0);
    @(posedge clk);
    @(negedge clk);
    rd(RPEND, v); check("R1 set after third edge", v, 1);
    gpio_in[0] = 1'b0;
    settle();
    clear_pend();
    wr(RISE_EN, 0);

    // R2/R4/R5/R8: sweep every line and every enable combination
    for (int l = 0; l < NL; l++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] bit_l;
        logic [31:0] er, ef;
        bit_l = 32'd1 << l;
        er = c[0] ? bit_l : 0;
        ef = c[1] ? bit_l : 0;
        wr(RISE_EN, er);
        wr(FALL_EN, ef);
        wr(IRQM, bit_l);
        wr(EVTM, bit_l);
        set_line(l, 1'b1);
        settle();
        check($sformatf("R5 rise evt line %0d cfg %0d", l, c), 32'(evt_o), er);
        rd(RPEND, v); check($sformatf("R2 R8 rise pend line %0d cfg %0d", l, c), v, er);
        rd(FPEND, v); check($sformatf("R2 fall pend after rise line %0d", l), v, 0);
        check($sformatf("R4 irq after rise line %0d cfg %0d", l, c), {31'b0, irq_o}, {31'b0, c[0]});
        @(negedge clk);
        check($sformatf("R5 single cycle line %0d", l), 32'(evt_o), 0);
        set_line(l, 1'b0);
        settle();
        check($sformatf("R5 fall evt line %0d cfg %0d", l, c), 32'(evt_o), ef);
        rd(FPEND, v); check($sformatf("R2 fall pend line %0d cfg %0d", l, c), v, ef);
        rd(RPEND, v); check($sformatf("R3 rise pend kept line %0d", l), v, er);
        check($sformatf("R4 irq after fall line %0d cfg %0d", l, c), {31'b0, irq_o}, {31'b0, c != 0});
        clear_pend();
        check($sformatf("R4 irq cleared line %0d", l), {31'b0, irq_o}, 0);
      end
    end
    wr(RISE_EN, 0); wr(FALL_EN, 0); wr(IRQM, 0); wr(EVTM, 0);

    // R6 and R3: software trigger and partial clear
    wr(SWTRIG, 32'h3);
    rd(RPEND, v);  check("R6 swtrig sets rise pend", v, 32'h3);
    rd(FPEND, v);  check("R6 swtrig leaves fall pend", v, 0);
    rd(SWTRIG, v); check("R6 swtrig reads zero", v, 0);
    wr(RPEND, 32'h1);
    rd(RPEND, v);  check("R3 clear only written ones", v, 32'h2);
    wr(RPEND, 32'h0);
    rd(RPEND, v);  check("R3 zero write keeps bits", v, 32'h2);
    wr(IRQM, 32'h2);
    check("R4 irq from masked pending", {31'b0, irq_o}, 1);
    wr(IRQM, 32'h1);
    check("R4 irq masked off", {31'b0, irq_o}, 0);
    wr(IRQM, 0);
    clear_pend();

    // R5: event independent of pending and of irq mask
    wr(RISE_EN, 32'd1 << 17);
    wr(EVTM, 32'd1 << 17);
    direct_in[1] = 1'b1;
    settle();
    check("R5 evt with irq mask clear", 32'(evt_o), 32'd1 << 17);
    check("R4 no irq when unmasked", {31'b0, irq_o}, 0);
    direct_in[1] = 1'b0;
    settle();
    direct_in[1] = 1'b1;
    settle();
    check("R5 evt while already pending", 32'(evt_o), 32'd1 << 17);
    rd(RPEND, v); check("R5 pend stays set", v, 32'd1 << 17);
    direct_in[1] = 1'b0;
    settle();
    wr(RISE_EN, 0); wr(EVTM, 0);
    clear_pend();

    // R7: selector routing for line 5 (address 13, bits 8 and up)
    wr(RISE_EN, 32'd1 << 5);
    for (int s = 0; s < (1 << SW); s++) begin
      wr(PSEL1, 32'(s) << 8);
      for (int p = 0; p < NP; p++) begin
        gpio_in[p*16+5] = 1'b1;
        settle();
        rd(RPEND, v);
        check($sformatf("R7 sel %0d port %0d", s, p), (v >> 5) & 1, (p == s) ? 1 : 0);
        gpio_in[p*16+5] = 1'b0;
        settle();
        clear_pend();
      end
    end
    wr(PSEL1, 32'hFFFF_FFFF);
    rd(PSEL1, v);
    check("R7 field readback", v, {4{8'((1 << SW) - 1)}});
    wr(PSEL1, 0);
    wr(RISE_EN, 0);

    // R9/R10/R11: attributes and lock
    wr(PRIV, 32'd1 << 2, 1'b0, 1'b1);
    rd(PRIV, v); check("R10 unprivileged priv write ignored", v, 0);
    wr(PRIV, 32'd1 << 2);
    rd(PRIV, v); check("R10 privileged priv write", v, 32'h4);
    wr(IRQM, allm, 1'b0, 1'b1);
    rd(IRQM, v); check("R9 unpriv write skips priv line", v, allm & ~32'h4);
    wr(IRQM, allm);
    rd(IRQM, v); check("R9 priv write reaches priv line", v, allm);
    wr(SWTRIG, 32'h4, 1'b0, 1'b1);
    rd(RPEND, v); check("R9 unpriv swtrig ignored", v, 0);
    wr(SEC, 32'h8, 1'b1, 1'b0);
    rd(SEC, v); check("R10 nonsecure sec write ignored", v, 0);
    wr(SEC, 32'h8);
    rd(SEC, v); check("R10 secure sec write", v, 32'h8);
    wr(IRQM, 0, 1'b1, 1'b0);
    rd(IRQM, v); check("R9 nonsecure write skips secure line", v, 32'h8);
    wr(PRIV, 32'hC, 1'b1, 1'b0);
    rd(PRIV, v); check("R10 nonsecure priv write skips secure line", v, 32'h4);
    wr(LOCK, 1, 1'b0, 1'b1);
    rd(LOCK, v); check("R11 unpriv lock ignored", v, 0);
    wr(LOCK, 1);
    rd(LOCK, v); check("R11 lock set", v, 1);
    wr(PRIV, 0);
    rd(PRIV, v); check("R11 priv frozen", v, 32'h4);
    wr(SEC, 0);
    rd(SEC, v); check("R11 sec frozen", v, 32'h8);
    wr(LOCK, 0);
    rd(LOCK, v); check("R11 lock sticky", v, 1);
    wr(IRQM, 0);
    rd(IRQM, v); check("R9 masks writable under lock", v, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(LOCK, v); check("R11 lock cleared by reset", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule